// File: doc/BRIEF.md
# Serial DAC Word Loader with Edge-Count Range Selection

This block is the digital front end of a current-output DAC. A host drives three wires: a serial clock, a data line and a load strobe. Every rising serial-clock edge shifts one data bit into an input register, most significant bit first. A rising edge on the load strobe copies that register into the output code register in parallel and pulses an update strobe for one system clock.

The host never writes a mode register. The block counts the serial-clock edges between two load strobes, modulo 32, and picks the range from that count. A count from 0 to 16 gives a normal-range word: the last 16 bits shifted in, zero-extended to the 17-bit output, where all zeros is the bottom of the 4 mA to 20 mA span. A count from 17 to 31 gives an alarm-range word: the last 17 bits shifted in, covering 0 mA to 32 mA. Longer writes, such as three bytes, therefore keep only their tail. All three pins are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are detected in the system clock domain, which must run at least four times faster than the serial clock.

Top module: `dac_serial_loader`

## Requirements
- R1: While `rst_n` is low and after its release, `code_o` is 0, `alarm_o` is 0 and `upd_o` is 0 until the first load strobe.
- R2: With exactly 16 serial-clock rising edges between load strobes, bits are taken MSB first and `code_o` becomes {1'b0, word[15:0]}, with `alarm_o` = 0.
- R3: With 17 to 31 edges, `alarm_o` = 1 and `code_o` holds the last 17 bits shifted in. Bit 16 is the bit sampled on the 17th edge before the strobe (for example, 24 edges keep only the last 17).
- R4: The edge count is taken modulo 32. Counts of 0, 32 and 48 give normal range (the last 16 bits). A count of 49 gives alarm range.
- R5: With fewer than 16 edges, normal range still applies, and `code_o[15:0]` holds the last 16 bits in the shift register, including bits left over from earlier writes.
- R6: Each rising edge of `ser_ld_i` produces exactly one single-cycle `upd_o` pulse, in the same cycle that `code_o` and `alarm_o` take their new value. The output is registered three system clocks after the strobe pin rises.
- R7: Serial-clock edges with no load strobe leave `code_o` and `alarm_o` unchanged and produce no `upd_o`.
- R8: Pulling `rst_n` low in the middle of a write clears the latched code, the range flag and the edge count. The next 16-edge write is then decoded as normal range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_ld_i | input | 1 | Load strobe; its rising edge transfers the word |
| code_o | output | 17 | Latched DAC code (bit 16 is 0 in normal range) |
| alarm_o | output | 1 | 1 when the latched word is alarm range |
| upd_o | output | 1 | One-cycle pulse when a new code is latched |

## Verification
The hardest situations to reach from the pins are edge counts that wrap past 32, and short writes whose result depends on bits left behind by an earlier write. The bench reaches them with writes of 8, 17, 24, 32, 48 and 49 bits, in an order that leaves known stale bits in the shift register. It also resets in the middle of a partial write. A behavioural model fed from the same pin samples is compared with the outputs every cycle. Directed checks with hand-computed codes confirm each case.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  localparam int unsigned DSL_NORM_BITS  = 16;
  localparam int unsigned DSL_ALARM_BITS = 17;
  localparam int unsigned DSL_CNT_BITS   = 5;
  localparam int unsigned DSL_SYNC_STAGES = 2;

  typedef enum logic {
    RANGE_NORMAL = 1'b0,
    RANGE_ALARM  = 1'b1
  } dsl_range_e;
endpackage

// File: rtl/dsl_sync.sv
module dsl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d[0] = pin_i;
    for (int i = 1; i <= STAGES; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R6: a detected rising edge never lasts two cycles
  a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dsl_shift.sv
module dsl_shift #(
  parameter int unsigned ALARM_BITS = 17,
  parameter int unsigned CNT_BITS   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en_i,
  input  logic                  bit_i,
  input  logic                  clr_cnt_i,
  output logic [ALARM_BITS-1:0] sr_o,
  output logic [CNT_BITS-1:0]   cnt_o
);
  logic [ALARM_BITS-1:0] sr_q, sr_d;
  logic [CNT_BITS-1:0]   cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (shift_en_i) begin
      sr_d  = {sr_q[ALARM_BITS-2:0], bit_i};
      cnt_d = cnt_q + 1'b1;            // wraps modulo 2**CNT_BITS
    end
    if (clr_cnt_i) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (shift_en_i) sr_q <= sr_d;
      if (shift_en_i || clr_cnt_i) cnt_q <= cnt_d;
    end
  end

  assign sr_o  = sr_q;
  assign cnt_o = cnt_q;

  // R4: the edge count restarts after every load strobe
  a_r4_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt_i |=> (cnt_q == '0));
  // R7: with no serial edge the shift register holds
  a_r7_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(sr_q));
endmodule

// File: rtl/dsl_latch.sv
module dsl_latch
  import dsl_pkg::*;
#(
  parameter int unsigned NORM_BITS  = 16,
  parameter int unsigned ALARM_BITS = 17,
  parameter int unsigned CNT_BITS   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [ALARM_BITS-1:0] sr_i,
  input  logic [CNT_BITS-1:0]   cnt_i,
  output logic [ALARM_BITS-1:0] code_o,
  output logic                  alarm_o,
  output logic                  upd_o
);
  localparam int unsigned PAD_BITS = ALARM_BITS - NORM_BITS;
  localparam logic [CNT_BITS-1:0] NORM_LIMIT = CNT_BITS'(NORM_BITS);

  logic [ALARM_BITS-1:0] code_q, code_d;
  dsl_range_e            rng_q, rng_d;
  logic                  upd_q, upd_d;

  always_comb begin
    code_d = code_q;
    rng_d  = rng_q;
    upd_d  = 1'b0;
    if (load_i) begin
      upd_d = 1'b1;
      if (cnt_i > NORM_LIMIT) begin
        rng_d  = RANGE_ALARM;
        code_d = sr_i;
      end else begin
        rng_d  = RANGE_NORMAL;
        code_d = {{PAD_BITS{1'b0}}, sr_i[NORM_BITS-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      rng_q  <= RANGE_NORMAL;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= upd_d;
      if (load_i) begin
        code_q <= code_d;
        rng_q  <= rng_d;
      end
    end
  end

  assign code_o  = code_q;
  assign alarm_o = (rng_q == RANGE_ALARM);
  assign upd_o   = upd_q;

  // R6: update strobe is one cycle wide
  a_r6_upd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
  // R7: the code only moves in a cycle flagged by the update strobe
  a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> ($stable(code_q) && $stable(rng_q)));
  // R2: a normal-range word has its extra high bits at zero
  a_r2_norm_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (rng_q == RANGE_NORMAL) |-> (code_q[ALARM_BITS-1:NORM_BITS] == '0));
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader
  import dsl_pkg::*;
#(
  parameter int unsigned NORM_BITS   = DSL_NORM_BITS,
  parameter int unsigned ALARM_BITS  = DSL_ALARM_BITS,
  parameter int unsigned CNT_BITS    = DSL_CNT_BITS,
  parameter int unsigned SYNC_STAGES = DSL_SYNC_STAGES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk_i,
  input  logic                  ser_dat_i,
  input  logic                  ser_ld_i,
  output logic [ALARM_BITS-1:0] code_o,
  output logic                  alarm_o,
  output logic                  upd_o
);
  localparam int unsigned N_PINS = 3;
  localparam int unsigned P_DAT = 0;
  localparam int unsigned P_CLK = 1;
  localparam int unsigned P_LD  = 2;

  logic [N_PINS-1:0] pin_w, lvl_w, rise_w;
  logic [ALARM_BITS-1:0] sr_w;
  logic [CNT_BITS-1:0]   cnt_w;

  assign pin_w = {ser_ld_i, ser_clk_i, ser_dat_i};

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    dsl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_w[g]),
      .lvl_o  (lvl_w[g]),
      .rise_o (rise_w[g])
    );
  end

  dsl_shift #(.ALARM_BITS(ALARM_BITS), .CNT_BITS(CNT_BITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_i (rise_w[P_CLK]),
    .bit_i      (lvl_w[P_DAT]),
    .clr_cnt_i  (rise_w[P_LD]),
    .sr_o       (sr_w),
    .cnt_o      (cnt_w)
  );

  dsl_latch #(.NORM_BITS(NORM_BITS), .ALARM_BITS(ALARM_BITS), .CNT_BITS(CNT_BITS)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (rise_w[P_LD]),
    .sr_i    (sr_w),
    .cnt_i   (cnt_w),
    .code_o  (code_o),
    .alarm_o (alarm_o),
    .upd_o   (upd_o)
  );

  // R3: alarm range is only reported together with a word that was latched
  a_r3_alarm_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> upd_o);
endmodule

// File: tb/sim_dac_serial_loader.sv
module sim_dac_serial_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
  logic [16:0] code_o;
  logic alarm_o, upd_o;

  int checks = 0;
  int fails = 0;
  int upd_seen = 0;
  bit run_cmp = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  dac_serial_loader u0 (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_ld_i(ser_ld),
    .code_o(code_o), .alarm_o(alarm_o), .upd_o(upd_o)
  );

  // ---------------- behavioural reference model ----------------
  // Pins seen at a system edge reach the outputs two edges later.
  logic [2:0] hist [0:2];     // samples: [0] newest
  bit q [$];                  // all serial bits taken, oldest first
  int edges_m = 0;
  logic [16:0] m_code = '0;
  logic m_alarm = 1'b0;
  logic m_upd = 1'b0;

  function automatic logic [16:0] tail_bits(int n);
    logic [16:0] v = '0;
    for (int i = 0; i < n; i++)
      if (q.size() > i) v[i] = q[q.size()-1-i];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) hist[i] = '0;
      q.delete();
      edges_m = 0; m_code = '0; m_alarm = 1'b0; m_upd = 1'b0;
    end else begin
      m_upd = 1'b0;
      // hist[1] = sample two edges ago, hist[2] = three edges ago
      if (hist[1][1] && !hist[2][1]) begin
        q.push_back(hist[1][0]);
        if (q.size() > 40) void'(q.pop_front());
        edges_m++;
      end
      if (hist[1][2] && !hist[2][2]) begin
        if ((edges_m % 32) > 16) begin m_code = tail_bits(17); m_alarm = 1'b1; end
        else begin m_code = {1'b0, tail_bits(16)}; m_alarm = 1'b0; end
        m_upd = 1'b1;
        edges_m = 0;
      end
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = {ser_ld, ser_clk, ser_dat};
    end
  end

  always @(negedge clk) begin
    if (upd_o) upd_seen++;
    if (run_cmp && rst_n) begin
      checks++;
      if (upd_o !== m_upd) begin
        fails++; $display("FAIL R6 upd_o act=%0b exp=%0b t=%0t", upd_o, m_upd, $time);
      end
      checks++;
      if (code_o !== m_code) begin
        fails++; $display("FAIL R2 code_o act=%h exp=%h t=%0t", code_o, m_code, $time);
      end
      checks++;
      if (alarm_o !== m_alarm) begin
        fails++; $display("FAIL R3 alarm_o act=%0b exp=%0b t=%0t", alarm_o, m_alarm, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ser_dat = v[i];
      wait_n(2); ser_clk = 1'b1;
      wait_n(3); ser_clk = 1'b0;
      wait_n(1);
    end
  endtask

  task automatic strobe();
    @(negedge clk); ser_ld = 1'b1;
    wait_n(3); ser_ld = 1'b0;
    wait_n(4);
  endtask

  task automatic check(string tag, logic [16:0] exp_code, logic exp_alarm);
    checks++;
    if (code_o !== exp_code || alarm_o !== exp_alarm) begin
      fails++;
      $display("FAIL %s code act=%h exp=%h alarm act=%0b exp=%0b",
               tag, code_o, exp_code, alarm_o, exp_alarm);
    end
  endtask

  task automatic check_pulses(string tag, int exp_n);
    checks++;
    if (upd_seen != exp_n) begin
      fails++; $display("FAIL %s upd pulses act=%0d exp=%0d", tag, upd_seen, exp_n);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    wait_n(3);
    check("R1 in reset", 17'h0, 1'b0);
    checks++;
    if (upd_o !== 1'b0) begin fails++; $display("FAIL R1 upd act=%0b exp=0", upd_o); end
    @(negedge clk); rst_n = 1'b1;
    run_cmp = 1'b1;
    wait_n(3);
    check("R1 after release", 17'h0, 1'b0);

    // R2: 16-bit normal word, MSB first
    upd_seen = 0;
    send_bits(64'hA5C3, 16); strobe();
    check("R2 normal 16", 17'h0A5C3, 1'b0);
    check_pulses("R6 one pulse", 1);

    // R3: 24-bit write keeps only last 17 bits
    send_bits(64'hAB3C00, 24); strobe();
    check("R3 alarm 24", 17'h13C00, 1'b1);

    // R3: exactly 17 bits
    send_bits(64'h03800, 17); strobe();
    check("R3 alarm 17", 17'h03800, 1'b1);

    // R4: 48 edges -> 16 mod 32 -> normal
    send_bits({32'hDEADBEEF, 16'h1234}, 48); strobe();
    check("R4 count 48", 17'h01234, 1'b0);

    // R4: 32 edges -> 0 mod 32 -> normal
    send_bits(64'h9999_5555, 32); strobe();
    check("R4 count 32", 17'h05555, 1'b0);

    // R4: 49 edges -> 17 mod 32 -> alarm
    send_bits({32'hFFFFFFFF, 17'h10000}, 49); strobe();
    check("R4 count 49", 17'h10000, 1'b1);

    // R4: zero edges -> normal, low 16 of the shift register
    upd_seen = 0;
    strobe();
    check("R4 count 0", 17'h00000, 1'b0);
    check_pulses("R6 pulse on empty strobe", 1);

    // R5: short write keeps stale low bits
    send_bits(64'h00FF, 16); strobe();
    send_bits(64'h3C, 8); strobe();
    check("R5 short 8", 17'h0FF3C, 1'b0);

    // R7: clocking without a strobe changes nothing
    upd_seen = 0;
    send_bits(64'h1_FFFF, 17);
    wait_n(5);
    check("R7 no strobe", 17'h0FF3C, 1'b0);
    check_pulses("R7 no pulse", 0);
    strobe();
    check("R7 then strobe", 17'h1FFFF, 1'b1);

    // R8: reset in the middle of a write clears latch and edge count
    send_bits(64'h2AA, 10);
    @(posedge clk); #1 rst_n = 1'b0;
    wait_n(3);
    check("R8 reset clears", 17'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    wait_n(3);
    send_bits(64'h0F0F, 16); strobe();
    check("R8 count cleared", 17'h00F0F, 1'b0);

    wait_n(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule